// File: doc/BRIEF.md
# BCD Clock Calendar Core with Read Freeze

This block keeps time of day and calendar date in packed BCD. A prescaler divides the core clock down to one tick per hundredth of a second. Each tick advances a cascade of counters: hundredths, seconds, minutes, hours (24-hour), day of week, date, month and two-digit year. Every carry ripples through in the same tick. Month lengths of 28, 29, 30 and 31 days are applied automatically, and any year divisible by four counts as a leap year.

Software does not see the running counters directly. It sees a block of shadow registers at the top of a 15-bit address space, reached through a simple single-cycle read and write port. The serial bus controller that owns this port also signals its STOP condition to the block. The shadow registers follow the counters, with three exceptions:

- Copying pauses while the bus is reading clock registers, so that a multi-byte read returns one coherent snapshot.
- Copying pauses while software holds the clock-edit bit, so that edits are not overwritten.
- Clearing the clock-edit bit commits the shadow registers into the counters and restarts the prescaler. This is how the time is set.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read: hundredths 00h, control 00h, seconds 00h, minutes 00h, hours 00h, day 01h, date 01h, month 01h, year 00h.
- R2: The hundredths register advances by one BCD count every PRESCALE core clocks while running, and wraps from 99h to 00h with a carry into seconds.
- R3: Seconds wrap 59h to 00h, minutes wrap 59h to 00h and hours wrap 23h to 00h. A day carry moves day of week (bits 2:0 of 7FFCh, values 1 to 7) from 7 back to 1. All carries take effect on the same tick.
- R4: The date returns to 01h after the last day of the month. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by four and 28 days otherwise. All other months have 31 days. Month 12h wraps to 01h with a year increment, and year 99h wraps to 00h.
- R5: Writing control register 7FF8h with bit 7 set (the clock-edit bit) clears the hundredths register 7FF7h to 00h. While the bit stays set, the shadow registers stop following the counters.
- R6: Writing 7FF8h with bit 7 clear while the clock-edit bit is set loads every shadow time field into the counters and restarts the prescaler from zero. The next hundredths increment then comes PRESCALE clocks after the commit.
- R7: While the clock-edit bit is clear, writes to the time fields at 7FF9h (bits 6:0) through 7FFFh leave those fields unchanged. Control bits 6:0 are stored and read back.
- R8: Bit 7 of seconds register 7FF9h is the halt bit. It is writable whether or not the clock-edit bit is set. While it is 1, all counters hold. Writing it back to 0 resumes counting.
- R9: A read of any address from 7FF9h to 7FFFh freezes the shadow registers. The freeze ends on a bus STOP pulse, or on a read or write to an address below 7FF0h.
- R10: Register map: 7FF7h hundredths, 7FF8h control, 7FF9h seconds, 7FFAh minutes, 7FFBh hours, 7FFCh day, 7FFDh date, 7FFEh month, 7FFFh year. Read data appears one clock after the read strobe. Addresses below 7FF7h read as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Single-cycle read strobe |
| acc_wr | input | 1 | Single-cycle write strobe |
| acc_addr | input | 15 | Byte address of the access |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data, valid the clock after acc_rd |
| bus_stop | input | 1 | One-cycle pulse marking a bus STOP condition |

## Verification
A commit from the clock-edit bit can land in the same cycle as a prescaler tick. The commit must win, and the prescaler must restart, so the elapsed hundredths are counted from the commit edge alone. The bench starts commits at every phase of the prescaler. It then reads the hundredths register at fixed clock distances and compares the result with the count of whole prescaler periods. A freeze release can also coincide with a counter carry. This is judged by reading seconds around a STOP pulse and a RAM access, and requiring that the first value seen after the release reflects the elapsed time.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_HUND = 15'h7FF7;
    localparam logic [ADDR_W-1:0] A_CTRL = 15'h7FF8;
    localparam logic [ADDR_W-1:0] A_SEC  = 15'h7FF9;
    localparam logic [ADDR_W-1:0] A_MIN  = 15'h7FFA;
    localparam logic [ADDR_W-1:0] A_HOUR = 15'h7FFB;
    localparam logic [ADDR_W-1:0] A_DAY  = 15'h7FFC;
    localparam logic [ADDR_W-1:0] A_DATE = 15'h7FFD;
    localparam logic [ADDR_W-1:0] A_MON  = 15'h7FFE;
    localparam logic [ADDR_W-1:0] A_YEAR = 15'h7FFF;
    localparam logic [ADDR_W-1:0] A_RSVD_LO = 15'h7FF0;

    typedef enum logic [1:0] {
        RG_RAM   = 2'd0,
        RG_RSVD  = 2'd1,
        RG_CTL   = 2'd2,
        RG_CLOCK = 2'd3
    } region_e;

    typedef struct packed {
        logic [7:0] hund;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    localparam rtc_time_t TIME_RESET = '{
        hund: 8'h00, sec: 7'h00, min: 7'h00, hour: 6'h00,
        dow: 3'd1, date: 6'h01, mon: 5'h01, year: 8'h00
    };

    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        if (a >= A_SEC)          return RG_CLOCK;
        else if (a >= A_HUND)    return RG_CTL;
        else if (a >= A_RSVD_LO) return RG_RSVD;
        else                     return RG_RAM;
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [7:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                     return is_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                   return 6'h31;
        endcase
    endfunction

    function automatic rtc_time_t time_step(input rtc_time_t t);
        rtc_time_t n;
        logic [7:0] w;
        n = t;
        if (t.hund != 8'h99) begin
            n.hund = bcd_inc(t.hund);
        end else begin
            n.hund = 8'h00;
            if (t.sec != 7'h59) begin
                w = bcd_inc({1'b0, t.sec});
                n.sec = w[6:0];
            end else begin
                n.sec = 7'h00;
                if (t.min != 7'h59) begin
                    w = bcd_inc({1'b0, t.min});
                    n.min = w[6:0];
                end else begin
                    n.min = 7'h00;
                    if (t.hour != 6'h23) begin
                        w = bcd_inc({2'b0, t.hour});
                        n.hour = w[5:0];
                    end else begin
                        n.hour = 6'h00;
                        n.dow  = (t.dow == 3'd7) ? 3'd1 : t.dow + 3'd1;
                        if (t.date != month_last(t.mon, t.year)) begin
                            w = bcd_inc({2'b0, t.date});
                            n.date = w[5:0];
                        end else begin
                            n.date = 6'h01;
                            if (t.mon != 5'h12) begin
                                w = bcd_inc({3'b0, t.mon});
                                n.mon = w[4:0];
                            end else begin
                                n.mon  = 5'h01;
                                n.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
                            end
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESCALE = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      halt,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= TIME_RESET;
        end else if (load) begin
            cur <= load_val;
        end else if (tick && !halt) begin
            cur <= time_step(cur);
        end
    end
endmodule

// File: rtl/rtc_freeze_ctl.sv
module rtc_freeze_ctl
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bus_stop,
    output logic              frozen
);
    region_e rg;
    logic    rel_ram;
    logic    set_clk;

    assign rg      = region_of(addr);
    assign rel_ram = (rd_en || wr_en) && (rg == RG_RAM);
    assign set_clk = rd_en && (rg == RG_CLOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen <= 1'b0;
        end else if (bus_stop || rel_ram) begin
            frozen <= 1'b0;
        end else if (set_clk) begin
            frozen <= 1'b1;
        end
    end
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frozen,
    input  rtc_time_t         cur,
    output rtc_time_t         sh,
    output logic              edit,
    output logic              halt,
    output logic              commit,
    output logic [DATA_W-1:0] rdata
);
    logic [6:0] ctl_low;
    logic       ctl_wr;
    logic       edit_rise;

    assign ctl_wr    = wr_en && (addr == A_CTRL);
    assign edit_rise = ctl_wr && wdata[7] && !edit;
    assign commit    = ctl_wr && !wdata[7] && edit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= TIME_RESET;
            edit    <= 1'b0;
            halt    <= 1'b0;
            ctl_low <= '0;
        end else begin
            if (!edit && !frozen) begin
                sh <= cur;
            end
            if (wr_en) begin
                case (addr)
                    A_CTRL: begin
                        edit    <= wdata[7];
                        ctl_low <= wdata[6:0];
                        if (edit_rise) sh.hund <= 8'h00;
                    end
                    A_SEC: begin
                        halt <= wdata[7];
                        if (edit) sh.sec <= wdata[6:0];
                    end
                    A_MIN:  if (edit) sh.min  <= wdata[6:0];
                    A_HOUR: if (edit) sh.hour <= wdata[5:0];
                    A_DAY:  if (edit) sh.dow  <= wdata[2:0];
                    A_DATE: if (edit) sh.date <= wdata[5:0];
                    A_MON:  if (edit) sh.mon  <= wdata[4:0];
                    A_YEAR: if (edit) sh.year <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                A_HUND:  rdata <= sh.hund;
                A_CTRL:  rdata <= {edit, ctl_low};
                A_SEC:   rdata <= {halt, sh.sec};
                A_MIN:   rdata <= {1'b0, sh.min};
                A_HOUR:  rdata <= {2'b0, sh.hour};
                A_DAY:   rdata <= {5'b0, sh.dow};
                A_DATE:  rdata <= {2'b0, sh.date};
                A_MON:   rdata <= {3'b0, sh.mon};
                A_YEAR:  rdata <= sh.year;
                default: rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              bus_stop
);
    rtc_time_t cur_time;
    rtc_time_t sh_time;
    logic      tick;
    logic      halt;
    logic      edit;
    logic      commit;
    logic      frozen;

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (commit),
        .run   (!halt),
        .tick  (tick)
    );

    rtc_time_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .halt     (halt),
        .load     (commit),
        .load_val (sh_time),
        .cur      (cur_time)
    );

    rtc_freeze_ctl u_frz (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (acc_rd),
        .wr_en    (acc_wr),
        .addr     (acc_addr),
        .bus_stop (bus_stop),
        .frozen   (frozen)
    );

    rtc_shadow_regs u_shd (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (acc_rd),
        .wr_en  (acc_wr),
        .addr   (acc_addr),
        .wdata  (acc_wdata),
        .frozen (frozen),
        .cur    (cur_time),
        .sh     (sh_time),
        .edit   (edit),
        .halt   (halt),
        .commit (commit),
        .rdata  (acc_rdata)
    );
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              tick,
    input logic              halt,
    input logic              edit,
    input logic              commit,
    input logic              frozen,
    input rtc_time_t         cur_time,
    input rtc_time_t         sh_time
);
    p_hund_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !halt && !commit && cur_time.hund == 8'h99) |=> (cur_time.hund == 8'h00));

    p_edit_clears_hund_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTRL && wdata[7] && !edit) |=> (sh_time.hund == 8'h00));

    p_edit_holds_shadow_r5: assert property (@(posedge clk) disable iff (rst)
        (edit && !wr_en) |=> $stable(sh_time));

    p_commit_loads_r6: assert property (@(posedge clk) disable iff (rst)
        commit |=> (cur_time == $past(sh_time)));

    p_commit_restarts_r6: assert property (@(posedge clk) disable iff (rst)
        commit |=> !tick);

    p_halt_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (halt && !commit) |=> $stable(cur_time));

    p_freeze_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (frozen && !wr_en) |=> $stable(sh_time));
endmodule

bind bcd_rtc_core rtc_core_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (acc_wr),
    .addr     (acc_addr),
    .wdata    (acc_wdata),
    .tick     (tick),
    .halt     (halt),
    .edit     (edit),
    .commit   (commit),
    .frozen   (frozen),
    .cur_time (cur_time),
    .sh_time  (sh_time)
);

// File: tb/sim_bcd_rtc_core.sv
module sim_bcd_rtc_core;
    localparam int PS = 4;
    localparam logic [14:0] AH = 15'h7FF7, AC = 15'h7FF8, AS = 15'h7FF9, AM = 15'h7FFA,
                            AHR = 15'h7FFB, AD = 15'h7FFC, ADT = 15'h7FFD, AMO = 15'h7FFE,
                            AY = 15'h7FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd = 1'b0, wr = 1'b0, stp = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    bcd_rtc_core #(.PRESCALE(PS)) u0 (
        .clk(clk), .rst(rst), .acc_rd(rd), .acc_wr(wr), .acc_addr(addr),
        .acc_wdata(wdata), .acc_rdata(rdata), .bus_stop(stp)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [14:0] a, output logic [7:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic stop_pulse();
        @(negedge clk); stp = 1'b1;
        @(negedge clk); stp = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, y);
        wr_reg(AC, 8'h80);
        wr_reg(AS, s);   wr_reg(AM, m);   wr_reg(AHR, h); wr_reg(AD, dw);
        wr_reg(ADT, dt); wr_reg(AMO, mo); wr_reg(AY, y);
        wr_reg(AC, 8'h00);
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(AH, v);  chk("R1 hundredths", v, 8'h00);
        rd_reg(AC, v);  chk("R1 control", v, 8'h00);
        rd_reg(AS, v);  chk("R1 seconds", v, 8'h00);
        rd_reg(AM, v);  chk("R1 minutes", v, 8'h00);
        rd_reg(AHR, v); chk("R1 hours", v, 8'h00);
        rd_reg(AD, v);  chk("R1 day", v, 8'h01);
        rd_reg(ADT, v); chk("R1 date", v, 8'h01);
        rd_reg(AMO, v); chk("R1 month", v, 8'h01);
        rd_reg(AY, v);  chk("R1 year", v, 8'h00);
        rd_reg(15'h0040, v); chk("R10 RAM read", v, 8'h00);
        stop_pulse();
    endtask

    // R2 and R6: hundredths count from the commit edge, for every prescaler phase
    task automatic t_rate();
        logic [7:0] v;
        for (int off = 0; off < 4; off++) begin
            stop_pulse();
            repeat (off) @(negedge clk);
            set_time(8'h30, 8'h10, 8'h08, 8'h02, 8'h15, 8'h06, 8'h10);
            repeat (39 + off) @(negedge clk);
            rd_reg(AH, v);
            chk("R2 R6 hundredths after commit", v, to_bcd((39 + off) / PS));
            rd_reg(AS, v);
            chk("R6 seconds loaded", v, 8'h30);
        end
        stop_pulse();
    endtask

    task automatic t_roll(input string req, input logic [7:0] s, m, h, dw, dt, mo, y,
                          input logic [7:0] es, em, eh, edw, edt, emo, ey);
        logic [7:0] v;
        stop_pulse();
        set_time(s, m, h, dw, dt, mo, y);
        repeat (448) @(negedge clk);
        rd_reg(AH, v);  chk({req, " hundredths"}, v, 8'h12);
        rd_reg(AS, v);  chk({req, " seconds"}, v, es);
        rd_reg(AM, v);  chk({req, " minutes"}, v, em);
        rd_reg(AHR, v); chk({req, " hours"}, v, eh);
        rd_reg(AD, v);  chk({req, " day"}, v, edw);
        rd_reg(ADT, v); chk({req, " date"}, v, edt);
        rd_reg(AMO, v); chk({req, " month"}, v, emo);
        rd_reg(AY, v);  chk({req, " year"}, v, ey);
        stop_pulse();
    endtask

    task automatic t_edit();
        logic [7:0] v, s0;
        stop_pulse();
        wr_reg(AC, 8'h80);
        rd_reg(AH, v);  chk("R5 hundredths cleared", v, 8'h00);
        rd_reg(AS, s0);
        stop_pulse();
        repeat (500) @(negedge clk);
        rd_reg(AS, v);  chk("R5 shadow held while editing", v, s0);
        rd_reg(AH, v);  chk("R5 hundredths still zero", v, 8'h00);
        wr_reg(AC, 8'h00);
        stop_pulse();
    endtask

    task automatic t_ignore();
        logic [7:0] v;
        stop_pulse();
        set_time(8'h00, 8'h20, 8'h05, 8'h03, 8'h10, 8'h03, 8'h30);
        wr_reg(AM, 8'h45);
        wr_reg(ADT, 8'h22);
        wr_reg(AC, 8'h05);
        rd_reg(AC, v);  chk("R7 control low bits stored", v, 8'h05);
        rd_reg(AM, v);  chk("R7 minutes write ignored", v, 8'h20);
        rd_reg(ADT, v); chk("R7 date write ignored", v, 8'h10);
        wr_reg(AC, 8'h00);
        stop_pulse();
    endtask

    task automatic t_halt();
        logic [7:0] v, h1;
        stop_pulse();
        set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        wr_reg(AS, 8'h90);
        rd_reg(AH, h1);
        rd_reg(AS, v);  chk("R8 halt bit set, seconds kept", v, 8'h90);
        stop_pulse();
        repeat (600) @(negedge clk);
        rd_reg(AH, v);  chk("R8 hundredths held", v, h1);
        rd_reg(AS, v);  chk("R8 seconds held", v, 8'h90);
        wr_reg(AS, 8'h00);
        stop_pulse();
        repeat (600) @(negedge clk);
        rd_reg(AS, v);  chk("R8 resumed counting", v, 8'h11);
        stop_pulse();
    endtask

    task automatic t_freeze();
        logic [7:0] v;
        stop_pulse();
        set_time(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        rd_reg(AS, v);  chk("R9 first read", v, 8'h05);
        repeat (500) @(negedge clk);
        rd_reg(AS, v);  chk("R9 frozen seconds", v, 8'h05);
        stop_pulse();
        repeat (4) @(negedge clk);
        rd_reg(AS, v);  chk("R9 released by STOP", v, 8'h06);
        repeat (400) @(negedge clk);
        rd_reg(AS, v);  chk("R9 frozen again", v, 8'h06);
        rd_reg(15'h0100, v); chk("R10 RAM read zero", v, 8'h00);
        repeat (4) @(negedge clk);
        rd_reg(AS, v);  chk("R9 released by RAM access", v, 8'h07);
        stop_pulse();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_rate();
        t_roll("R3 R4 non-leap Feb end", 8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23,
               8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h23);
        t_roll("R4 leap Feb 28", 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24,
               8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24);
        t_roll("R4 leap Feb 29", 8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24,
               8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h24);
        t_roll("R4 30-day month", 8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h21,
               8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h21);
        t_roll("R4 31-day month day 30", 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h05,
               8'h00, 8'h00, 8'h00, 8'h03, 8'h31, 8'h01, 8'h05);
        t_roll("R3 R4 year wrap", 8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99,
               8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h00);
        t_roll("R3 minute carry only", 8'h59, 8'h34, 8'h12, 8'h02, 8'h11, 8'h07, 8'h44,
               8'h00, 8'h35, 8'h12, 8'h02, 8'h11, 8'h07, 8'h44);
        t_edit();
        t_ignore();
        t_halt();
        t_freeze();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule